// File: doc/BRIEF.md
# RS485 Driver-Enable Guard Controller

This block owns the driver-enable pin of a half-duplex RS485 transceiver that sits behind a UART transmitter. When the transmitter starts a frame, the block raises the enable so the line is driven before the start bit goes out. While more data is waiting, the enable stays up from one frame to the next, so the line is never released between back-to-back characters.

Once a stop bit has been sent and nothing else is queued, the block keeps the line driven for a programmable hold of 0 to 7 bit times, counted on the bit-time tick, and then releases it. The hold lets the last stop bit settle at the far end before the bus turns around. If new data shows up during the hold, the hold is dropped and the next frame goes out with the enable still high. When the RS485 function is switched off, the enable is forced low. The baud generator and the shift register are outside this block. They supply the tick and the frame strobes.

Top module: `rs485_de_guard`

## Requirements
- R1: While reset is applied, and after reset with no frame started, `drv_en` is 0.
- R2: With `rs485_mode` = 1, a `frame_start` pulse makes `drv_en` 1 in the next clock cycle.
- R3: A `stop_done` pulse seen while `data_pending` = 1 keeps `drv_en` at 1, so the enable stays up across back-to-back frames.
- R4: A `stop_done` pulse with `data_pending` = 0 and a `guard_sel` value N from 1 to 7 keeps `drv_en` at 1 through the next N-1 `bit_tick` pulses. `drv_en` goes to 0 in the cycle after the Nth `bit_tick` pulse. A tick that falls in the same cycle as `stop_done` is not counted.
- R5: A `stop_done` pulse with `data_pending` = 0 and `guard_sel` = 0 makes `drv_en` 0 in the next cycle.
- R6: The hold counts only `bit_tick` pulses. Without ticks, `drv_en` stays at 1 for as long as needed.
- R7: A `data_pending` or `frame_start` during the hold drops the hold and keeps `drv_en` at 1. The next `stop_done` with an empty queue starts a full new hold.
- R8: When `rs485_mode` = 0, `drv_en` is 0 from the next cycle on, and `frame_start` is ignored.
- R9: `guard_sel` is sampled at the `stop_done` that starts a hold. Changing it during the hold does not change that hold's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rs485_mode | input | 1 | 1 = RS485 driver-enable control is active |
| bit_tick | input | 1 | Single-cycle pulse, once per bit time |
| frame_start | input | 1 | Single-cycle pulse when the transmitter begins a frame |
| stop_done | input | 1 | Single-cycle pulse when a stop bit has been sent |
| data_pending | input | 1 | 1 = more data is queued for transmission |
| guard_sel | input | GUARD_W | Hold length in bit times, from 0 up to 2**GUARD_W-1 |
| drv_en | output | 1 | Registered driver-enable output to the transceiver |

## Verification
The bench uses the default `GUARD_W` = 3, so it can walk through every hold setting from 0 to 7. The walk covers the zero-hold release and the longest hold. It also drops a hold part-way through, changes `guard_sel` in the middle of a hold, and waits for long stretches with no tick. A random phase runs with a fixed seed and mixes ticks, strobes, queue state and mode changes. A cycle model in the bench compares `drv_en` against those random patterns in every cycle.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  typedef enum logic [1:0] {
    RSG_IDLE   = 2'd0,
    RSG_ACTIVE = 2'd1,
    RSG_GUARD  = 2'd2
  } rsg_state_t;

endpackage

// File: rtl/rsg_rst_sync.sv
module rsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rsg_guard_cnt.sv
module rsg_guard_cnt #(
  parameter int GUARD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [GUARD_W-1:0] load_val,
  input  logic               dec,
  output logic [GUARD_W-1:0] cnt_q,
  output logic               cnt_last
);

  localparam logic [GUARD_W-1:0] ONE = GUARD_W'(1);

  logic [GUARD_W-1:0] cnt_d;
  logic               cnt_ce;

  always_comb begin
    cnt_ce = load | dec;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_last = (cnt_q == ONE);

endmodule

// File: rtl/rsg_fsm.sv
module rsg_fsm
  import rsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rs485_mode,
  input  logic       bit_tick,
  input  logic       frame_start,
  input  logic       stop_done,
  input  logic       data_pending,
  input  logic       guard_zero,
  input  logic       cnt_last,
  output logic       cnt_load,
  output logic       cnt_dec,
  output rsg_state_t st_q,
  output logic       drv_en_q
);

  rsg_state_t st_d;
  logic       en_d;
  logic       queue_empty_end;

  always_comb begin
    queue_empty_end = stop_done & ~data_pending & ~frame_start;
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    if (!rs485_mode) begin
      st_d = RSG_IDLE;
    end else begin
      case (st_q)
        RSG_IDLE: begin
          if (frame_start) begin
            st_d = RSG_ACTIVE;
          end
        end
        RSG_ACTIVE: begin
          if (queue_empty_end) begin
            if (guard_zero) begin
              st_d = RSG_IDLE;
            end else begin
              st_d     = RSG_GUARD;
              cnt_load = 1'b1;
            end
          end
        end
        RSG_GUARD: begin
          if (frame_start || data_pending) begin
            st_d = RSG_ACTIVE;
          end else if (bit_tick) begin
            cnt_dec = 1'b1;
            if (cnt_last) begin
              st_d = RSG_IDLE;
            end
          end
        end
        default: st_d = RSG_IDLE;
      endcase
    end
    en_d = (st_d != RSG_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RSG_IDLE;
      drv_en_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      drv_en_q <= en_d;
    end
  end

endmodule

// File: rtl/rs485_de_guard.sv
module rs485_de_guard
  import rsg_pkg::*;
#(
  parameter int GUARD_W    = 3,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rs485_mode,
  input  logic               bit_tick,
  input  logic               frame_start,
  input  logic               stop_done,
  input  logic               data_pending,
  input  logic [GUARD_W-1:0] guard_sel,
  output logic               drv_en
);

  logic               rst_n_sync;
  logic [GUARD_W-1:0] cnt_q;
  logic               cnt_last;
  logic               cnt_load;
  logic               cnt_dec;
  logic               guard_zero;
  rsg_state_t         st_q;

  assign guard_zero = (guard_sel == '0);

  rsg_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rsg_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .rs485_mode   (rs485_mode),
    .bit_tick     (bit_tick),
    .frame_start  (frame_start),
    .stop_done    (stop_done),
    .data_pending (data_pending),
    .guard_zero   (guard_zero),
    .cnt_last     (cnt_last),
    .cnt_load     (cnt_load),
    .cnt_dec      (cnt_dec),
    .st_q         (st_q),
    .drv_en_q     (drv_en)
  );

  rsg_guard_cnt #(.GUARD_W(GUARD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .load     (cnt_load),
    .load_val (guard_sel),
    .dec      (cnt_dec),
    .cnt_q    (cnt_q),
    .cnt_last (cnt_last)
  );

endmodule

// File: rtl/rs485_de_guard_chk.sv
module rs485_de_guard_chk
  import rsg_pkg::*;
#(
  parameter int GUARD_W = 3
) (
  input logic               clk,
  input logic               rst_n_sync,
  input logic               rs485_mode,
  input logic               bit_tick,
  input logic               frame_start,
  input logic               stop_done,
  input logic               data_pending,
  input logic [GUARD_W-1:0] guard_sel,
  input logic               drv_en,
  input rsg_state_t         st_q,
  input logic [GUARD_W-1:0] cnt_q
);

  always @(posedge clk) begin
    if (!rst_n_sync) begin
      AST_RESET_LOW: assert (!drv_en); // R1
    end
  end

  AST_START_RISE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rs485_mode && frame_start |=> drv_en); // R2

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rs485_mode && st_q == RSG_ACTIVE && stop_done && data_pending
    |=> drv_en && st_q == RSG_ACTIVE); // R3

  AST_GUARD_LOAD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rs485_mode && st_q == RSG_ACTIVE && stop_done && !data_pending && !frame_start
    && guard_sel != '0 |=> drv_en && cnt_q == $past(guard_sel)); // R4

  AST_ZERO_GUARD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rs485_mode && st_q == RSG_ACTIVE && stop_done && !data_pending && !frame_start
    && guard_sel == '0 |=> !drv_en); // R5

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rs485_mode && st_q == RSG_GUARD && !bit_tick && !frame_start && !data_pending
    |=> drv_en && $stable(cnt_q)); // R6

  AST_ABANDON: assert property (@(posedge clk) disable iff (!rst_n_sync)
    rs485_mode && st_q == RSG_GUARD && (frame_start || data_pending)
    |=> drv_en && st_q == RSG_ACTIVE); // R7

  AST_MODE_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !rs485_mode |=> !drv_en); // R8

endmodule

bind rs485_de_guard rs485_de_guard_chk #(.GUARD_W(GUARD_W)) u_chk (.*);

// File: tb/rs485_de_guard_bench.sv
`timescale 1ns/1ps
module rs485_de_guard_bench;

  localparam int GW = 3;

  logic          clk;
  logic          rst_n;
  logic          rs485_mode;
  logic          bit_tick;
  logic          frame_start;
  logic          stop_done;
  logic          data_pending;
  logic [GW-1:0] guard_sel;
  logic          drv_en;

  int checks;
  int errors;
  bit done;

  // Bench model: 0 idle, 1 sending, 2 holding
  int m_st;
  int m_cnt;
  bit model_on;

  rs485_de_guard #(.GUARD_W(GW)) u_rs485_de_guard (
    .clk          (clk),
    .rst_n        (rst_n),
    .rs485_mode   (rs485_mode),
    .bit_tick     (bit_tick),
    .frame_start  (frame_start),
    .stop_done    (stop_done),
    .data_pending (data_pending),
    .guard_sel    (guard_sel),
    .drv_en       (drv_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int model_next_st(int st, int cnt, bit mode, bit fs, bit sd,
                                       bit dp, bit tk, int g);
    if (!mode) return 0;
    case (st)
      0: return fs ? 1 : 0;
      1: if (sd && !dp && !fs) return (g == 0) ? 0 : 2;
         else return 1;
      default: if (fs || dp) return 1;
               else if (tk && cnt == 1) return 0;
               else return 2;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st  <= 0;
      m_cnt <= 0;
    end else begin
      m_st <= model_next_st(m_st, m_cnt, rs485_mode, frame_start, stop_done,
                            data_pending, bit_tick, int'(guard_sel));
      if (rs485_mode && m_st == 1 && stop_done && !data_pending && !frame_start)
        m_cnt <= int'(guard_sel);
      else if (rs485_mode && m_st == 2 && !frame_start && !data_pending && bit_tick)
        m_cnt <= m_cnt - 1;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: drv_en=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !done) check(drv_en, logic'(m_st != 0), "R3 R4 R7 R8 model");
  end

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_fs();
    frame_start = 1'b1; @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_sd();
    stop_done = 1'b1; @(negedge clk); stop_done = 1'b0;
  endtask

  task automatic pulse_tick();
    bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0; model_on = 1'b0;
    rst_n = 1'b0; rs485_mode = 1'b0; bit_tick = 1'b0; frame_start = 1'b0;
    stop_done = 1'b0; data_pending = 1'b0; guard_sel = '0;
    idle_cycles(3);
    check(drv_en, 1'b0, "R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    idle_cycles(4);
    rs485_mode = 1'b1;
    idle_cycles(3);
    check(drv_en, 1'b0, "R1 idle after reset");
    model_on = 1'b1;

    // R2 start raises enable
    pulse_fs();
    check(drv_en, 1'b1, "R2 frame start");

    // R3 back-to-back frames
    data_pending = 1'b1;
    pulse_sd();
    check(drv_en, 1'b1, "R3 stop with data queued");
    pulse_fs();
    data_pending = 1'b0;
    idle_cycles(2);
    check(drv_en, 1'b1, "R3 second frame");

    // R4 R5 every guard setting
    for (int g = 0; g < 8; g++) begin
      guard_sel = GW'(g);
      pulse_sd();
      check(drv_en, logic'(g != 0), g == 0 ? "R5 zero guard" : "R4 guard start");
      for (int k = 1; k <= g; k++) begin
        pulse_tick();
        idle_cycles(1);
        check(drv_en, logic'(k < g), "R4 guard tick");
      end
      pulse_fs();
      check(drv_en, 1'b1, "R2 restart");
    end

    // R6 no ticks, no release
    guard_sel = 3'd3;
    pulse_sd();
    idle_cycles(60);
    check(drv_en, 1'b1, "R6 hold without ticks");
    pulse_tick();
    idle_cycles(100);
    check(drv_en, 1'b1, "R6 hold after one tick");
    pulse_tick();
    pulse_tick();
    check(drv_en, 1'b0, "R4 release after third tick");

    // R7 abandon hold on new data
    pulse_fs();
    guard_sel = 3'd5;
    pulse_sd();
    pulse_tick();
    pulse_tick();
    data_pending = 1'b1;
    @(negedge clk);
    data_pending = 1'b0;
    check(drv_en, 1'b1, "R7 abandoned hold");
    pulse_sd();
    for (int k = 1; k <= 5; k++) begin
      pulse_tick();
      check(drv_en, logic'(k < 5), "R7 full new hold");
    end

    // R9 guard setting change ignored mid-hold
    pulse_fs();
    guard_sel = 3'd2;
    pulse_sd();
    guard_sel = 3'd7;
    pulse_tick();
    check(drv_en, 1'b1, "R9 first tick");
    pulse_tick();
    check(drv_en, 1'b0, "R9 sampled length");

    // R8 mode off
    pulse_fs();
    rs485_mode = 1'b0;
    idle_cycles(1);
    check(drv_en, 1'b0, "R8 mode off drops enable");
    pulse_fs();
    idle_cycles(2);
    check(drv_en, 1'b0, "R8 frame start ignored");
    rs485_mode = 1'b1;
    idle_cycles(2);

    // Random phase, fixed seed
    void'($urandom(32'h5eed_0485));
    for (int i = 0; i < 20000; i++) begin
      bit_tick     = ($urandom_range(0, 2) == 0);
      frame_start  = ($urandom_range(0, 15) == 0);
      stop_done    = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 9) == 0) data_pending = ~data_pending;
      if ($urandom_range(0, 31) == 0) guard_sel = GW'($urandom_range(0, 7));
      rs485_mode   = ($urandom_range(0, 199) != 0);
      @(negedge clk);
    end
    bit_tick = 1'b0; frame_start = 1'b0; stop_done = 1'b0;
    idle_cycles(2);
    finish_run();
  end

endmodule